// File: doc/BRIEF.md
# Bit-Vector AND-and-Count Combine Element

This element merges two binary vectors of equal length and decides whether the merge is strong enough to keep. The vectors arrive W bits at a time through two operand FIFOs. Each pair of words is ANDed, and the ANDed word is pushed into a result FIFO so that a downstream writer can store the merged vector. The same word is loaded into a shift register that a small K-bit ones counter walks through, one slice per cycle, adding each slice count into a running total.

A job begins with a one-cycle `start` that carries the vector length, given as a count of W-bit words, and a threshold. When the last word has been counted, `done` rises. `ones_total` then holds the ones count of the whole merged vector, and `valid` tells whether that count reached the threshold. Both hold until the next job begins. When an operand FIFO is empty or the result FIFO is full, the element waits. It never drops or repeats a word.

Top module: `bvc_pe`

## Requirements
- R1: Each pair of operand words, taken in arrival order, yields exactly one result word equal to their bitwise AND, and result words leave the result FIFO in the same order.
- R2: At `done`, `ones_total` equals the number of 1 bits across all result words of the job. While the job runs, the total never decreases.
- R3: A `start` taken while `busy` is low clears `ones_total` to 0 on the following cycle and latches `word_count` and `threshold`. A `start` raised while `busy` is high is ignored and changes neither the job nor its results.
- R4: While `done` is high, `valid` is 1 exactly when `ones_total` is greater than or equal to the latched threshold. Equality counts as a pass.
- R5: Once `done` rises, `done`, `valid` and `ones_total` stay unchanged until the next accepted `start`.
- R6: With operands already queued and room in the result FIFO, `done` rises N·(1+W/K) clock edges after the edge that accepts `start`, for N words (W=64, K=8: 9 edges per word).
- R7: An empty operand FIFO or a full result FIFO stalls the element. No word is lost, duplicated or reordered, and no FIFO is pushed when full or popped when empty.
- R8: A job with `word_count` = 0 sets `done` on the cycle after `start`, with `ones_total` = 0 and `valid` = 1 only when the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a job |
| word_count | input | WC_W | Vector length in W-bit words, sampled with start |
| threshold | input | ACC_W | Minimum ones count for a pass, sampled with start |
| a_push | input | 1 | Write a word into operand FIFO A |
| a_data | input | W | Operand A word |
| a_full | output | 1 | Operand FIFO A cannot accept a word |
| b_push | input | 1 | Write a word into operand FIFO B |
| b_data | input | W | Operand B word |
| b_full | output | 1 | Operand FIFO B cannot accept a word |
| r_pop | input | 1 | Remove the head word of the result FIFO |
| r_data | output | W | Head word of the result FIFO |
| r_empty | output | 1 | Result FIFO holds no word |
| busy | output | 1 | A job is loading or counting |
| done | output | 1 | The current job has finished |
| valid | output | 1 | The finished job reached the threshold |
| ones_total | output | ACC_W | Running, then final, ones count |

## Verification
The embedded properties check on every cycle that no FIFO overflows or underflows, that the total only grows during a job, that an accepted start zeroes it, that load and slice-count never overlap, and that `valid` agrees with the latched threshold while results stay frozen after `done`. Properties cannot see the contents of the AND result stream, the exact per-word cycle cost, the effect of a start raised mid-job, or the zero-length case. The bench scenarios show these by comparing against vectors, ones counts and timings it computes itself, under random gaps on the operand side and back-pressure on the result side.

// File: rtl/bvc_pkg.sv
// Shared types for the bit-vector combine element.
package bvc_pkg;

    // Control phases of one combine job.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2,
        ST_DONE  = 2'd3
    } bvc_state_e;

endpackage

// File: rtl/bvc_fifo.sv
// Synchronous FIFO with a first-word-fall-through read port.
// Assumes: the user never pushes when full nor pops when empty.
// Push and pop in the same cycle are allowed.
module bvc_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign rdata = mem[rd_ptr];

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop)); // R7
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty)); // R7

endmodule

// File: rtl/bvc_slice_counter.sv
// Serial ones counter: holds one W-bit word in a shift register and, on
// each shift, adds the ones of its lowest K bits into an accumulator.
// Assumes: K divides W, and ACC_W is wide enough for the longest job.
module bvc_slice_counter #(
    parameter int W     = 64,
    parameter int K     = 8,
    parameter int ACC_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [W-1:0]     load_word,
    input  logic             shift,
    output logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] acc_next
);
    localparam int CNT_W = $clog2(K) + 1;

    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] slice_ones;

    // K-bit decoder: ones in the lowest slice.
    always_comb begin
        slice_ones = '0;
        for (int i = 0; i < K; i++) begin
            slice_ones = slice_ones + CNT_W'(shreg[i]);
        end
    end

    assign acc_next = acc + ACC_W'(slice_ones);

    // Shift register: load a fresh word or drop the counted slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= load_word;
        end else if (shift) begin
            shreg <= shreg >> K;
        end
    end

    // Accumulator: clear on a new job, add a slice on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
        end else if (shift) begin
            acc <= acc_next;
        end
    end

    AST_LOAD_SHIFT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift)); // R6
    AST_ACC_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (acc >= $past(acc))); // R2

endmodule

// File: rtl/bvc_pe.sv
// Bit-vector combine element. Pops paired words from two operand FIFOs,
// ANDs them, pushes the AND into a result FIFO and counts its ones K bits
// per cycle. At the end of an N-word job it flags whether the total
// reached the threshold latched at start.
// Assumes: K divides W; start is honoured only while not busy.
module bvc_pe #(
    parameter int W         = 64,
    parameter int K         = 8,
    parameter int DEPTH     = 4,
    parameter int MAX_WORDS = 256,
    parameter int WC_W      = $clog2(MAX_WORDS + 1),
    parameter int ACC_W     = $clog2(((2 ** WC_W) - 1) * W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WC_W-1:0]  word_count,
    input  logic [ACC_W-1:0] threshold,
    input  logic             a_push,
    input  logic [W-1:0]     a_data,
    output logic             a_full,
    input  logic             b_push,
    input  logic [W-1:0]     b_data,
    output logic             b_full,
    input  logic             r_pop,
    output logic [W-1:0]     r_data,
    output logic             r_empty,
    output logic             busy,
    output logic             done,
    output logic             valid,
    output logic [ACC_W-1:0] ones_total
);
    import bvc_pkg::*;

    localparam int SLICES = W / K;
    localparam int SL_W   = $clog2(SLICES + 1);

    bvc_state_e       state;
    logic [WC_W-1:0]  words_left;
    logic [SL_W-1:0]  slice_left;
    logic [ACC_W-1:0] thr_q;
    logic             valid_q;

    logic [W-1:0]     a_head;
    logic [W-1:0]     b_head;
    logic             a_empty;
    logic             b_empty;
    logic             r_full;
    logic             start_ok;
    logic             take_word;
    logic             counting;
    logic [W-1:0]     and_word;
    logic [ACC_W-1:0] acc_next;

    assign busy      = (state == ST_LOAD) || (state == ST_COUNT);
    assign done      = (state == ST_DONE);
    assign valid     = valid_q;
    assign start_ok  = start && !busy;
    assign take_word = (state == ST_LOAD) && !a_empty && !b_empty && !r_full;
    assign counting  = (state == ST_COUNT);
    assign and_word  = a_head & b_head;

    bvc_fifo #(.WIDTH(W), .DEPTH(DEPTH)) u_fifo_a (
        .clk(clk), .rst_n(rst_n),
        .push(a_push), .wdata(a_data),
        .pop(take_word), .rdata(a_head),
        .full(a_full), .empty(a_empty)
    );

    bvc_fifo #(.WIDTH(W), .DEPTH(DEPTH)) u_fifo_b (
        .clk(clk), .rst_n(rst_n),
        .push(b_push), .wdata(b_data),
        .pop(take_word), .rdata(b_head),
        .full(b_full), .empty(b_empty)
    );

    bvc_fifo #(.WIDTH(W), .DEPTH(DEPTH)) u_fifo_r (
        .clk(clk), .rst_n(rst_n),
        .push(take_word), .wdata(and_word),
        .pop(r_pop), .rdata(r_data),
        .full(r_full), .empty(r_empty)
    );

    bvc_slice_counter #(.W(W), .K(K), .ACC_W(ACC_W)) u_count (
        .clk(clk), .rst_n(rst_n),
        .clear(start_ok),
        .load(take_word), .load_word(and_word),
        .shift(counting),
        .acc(ones_total), .acc_next(acc_next)
    );

    // Job sequencing: start, per-word load, per-slice count, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            words_left <= '0;
            slice_left <= '0;
            thr_q      <= '0;
            valid_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        thr_q      <= threshold;
                        words_left <= word_count;
                        if (word_count == '0) begin
                            state   <= ST_DONE;
                            valid_q <= (threshold == '0);
                        end else begin
                            state   <= ST_LOAD;
                            valid_q <= 1'b0;
                        end
                    end
                end
                ST_LOAD: begin
                    if (take_word) begin
                        state      <= ST_COUNT;
                        slice_left <= SL_W'(SLICES - 1);
                    end
                end
                ST_COUNT: begin
                    if (slice_left == '0) begin
                        words_left <= words_left - 1'b1;
                        if (words_left == WC_W'(1)) begin
                            state   <= ST_DONE;
                            valid_q <= (acc_next >= thr_q);
                        end else begin
                            state <= ST_LOAD;
                        end
                    end else begin
                        slice_left <= slice_left - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_START_CLEARS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (ones_total == '0)); // R3
    AST_VALID_FOLLOWS_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (valid == (ones_total >= thr_q))); // R4
    AST_RESULTS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(valid) && $stable(ones_total))); // R5
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && r_full) |=> (state == ST_LOAD)); // R7

endmodule

// File: tb/bvc_pe_tb_top.sv
// Self-checking bench for bvc_pe: directed corners plus seeded random jobs.
module bvc_pe_tb_top;
    localparam int W     = 64;
    localparam int K     = 8;
    localparam int WC_W  = 9;
    localparam int ACC_W = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [WC_W-1:0]  word_count = '0;
    logic [ACC_W-1:0] threshold = '0;
    logic             a_push = 1'b0;
    logic [W-1:0]     a_data = '0;
    logic             a_full;
    logic             b_push = 1'b0;
    logic [W-1:0]     b_data = '0;
    logic             b_full;
    logic             r_pop = 1'b0;
    logic [W-1:0]     r_data;
    logic             r_empty;
    logic             busy;
    logic             done;
    logic             valid;
    logic [ACC_W-1:0] ones_total;

    int tests = 0;
    int fails = 0;

    logic [W-1:0] av[$];
    logic [W-1:0] bv[$];

    always #5 clk = ~clk;

    bvc_pe dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .word_count(word_count), .threshold(threshold),
        .a_push(a_push), .a_data(a_data), .a_full(a_full),
        .b_push(b_push), .b_data(b_data), .b_full(b_full),
        .r_pop(r_pop), .r_data(r_data), .r_empty(r_empty),
        .busy(busy), .done(done), .valid(valid), .ones_total(ones_total)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rnd_word(input int dens);
        logic [W-1:0] x;
        x = {$urandom(), $urandom()};
        if (dens == 0) x = x & {$urandom(), $urandom()};
        if (dens == 2) x = x | {$urandom(), $urandom()};
        return x;
    endfunction

    function automatic int expected_ones(input int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += $countones(av[i] & bv[i]);
        return s;
    endfunction

    function automatic logic [ACC_W-1:0] pick_thr(input int exp_ones, input int off);
        int t = exp_ones + off;
        if (t < 0) t = 0;
        return ACC_W'(t);
    endfunction

    task automatic final_checks(input int n, input logic [ACC_W-1:0] thr);
        int eo = expected_ones(n);
        check(done == 1'b1, "R2", "done at end", W'(done), 1);
        check(ones_total == ACC_W'(eo), "R2", "ones total", W'(ones_total), W'(eo));
        check(valid == (eo >= int'(thr)), "R4", "valid vs threshold", W'(valid), W'(eo >= int'(thr)));
        repeat (3) @(negedge clk);
        check(done && ones_total == ACC_W'(eo) && valid == (eo >= int'(thr)),
              "R5", "results held after done", W'(ones_total), W'(eo));
    endtask

    // One job with random operand gaps and result back-pressure.
    task automatic run_job(input int n, input int off, input int gap, input int hold,
                           input int dens, input bit poke_start);
        int ai = 0, bi = 0, ri = 0, cyc = 0;
        logic [ACC_W-1:0] thr;
        av.delete(); bv.delete();
        for (int i = 0; i < n; i++) begin
            av.push_back(rnd_word(dens));
            bv.push_back(rnd_word(dens));
        end
        thr = pick_thr(expected_ones(n), off);
        @(negedge clk);
        start = 1'b1; word_count = WC_W'(n); threshold = thr;
        @(negedge clk);
        start = 1'b0;
        while (!(done && ri == n) && cyc < 4000) begin
            cyc++;
            start = poke_start && (cyc == 5);
            if (start) begin word_count = 1; threshold = 0; end
            a_push = (ai < n) && !a_full && (($urandom() % 100) >= gap);
            a_data = (ai < n) ? av[ai] : '0;
            if (a_push) ai++;
            b_push = (bi < n) && !b_full && (($urandom() % 100) >= gap);
            b_data = (bi < n) ? bv[bi] : '0;
            if (b_push) bi++;
            r_pop = !r_empty && (($urandom() % 100) >= hold);
            if (r_pop) begin
                check(ri < n && r_data == (av[ri] & bv[ri]), "R1", "result word",
                      r_data, (ri < n) ? (av[ri] & bv[ri]) : '0);
                ri++;
            end
            @(negedge clk);
        end
        start = 1'b0; a_push = 1'b0; b_push = 1'b0; r_pop = 1'b0;
        check(cyc < 4000, "R7", "job completes under stalls", W'(cyc), 0);
        check(ri == n, "R7", "result word count", W'(ri), W'(n));
        final_checks(n, thr);
    endtask

    // Prefilled operands, free result space: exact cycle cost.
    task automatic timing_job(input int n);
        int edges = 0;
        av.delete(); bv.delete();
        for (int i = 0; i < n; i++) begin
            av.push_back(rnd_word(1));
            bv.push_back(rnd_word(1));
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            a_push = 1'b1; a_data = av[i]; b_push = 1'b1; b_data = bv[i];
        end
        @(negedge clk);
        a_push = 1'b0; b_push = 1'b0;
        start = 1'b1; word_count = WC_W'(n); threshold = pick_thr(expected_ones(n), 0);
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        while (!done && edges < 200) begin
            @(negedge clk);
            edges++;
        end
        check(edges == 1 + n * (1 + W / K), "R6", "edges from start to done",
              W'(edges), W'(1 + n * (1 + W / K)));
        for (int i = 0; i < n; i++) begin
            check(!r_empty && r_data == (av[i] & bv[i]), "R1", "prefilled result", r_data, av[i] & bv[i]);
            r_pop = 1'b1;
            @(negedge clk);
            r_pop = 1'b0;
        end
        final_checks(n, pick_thr(expected_ones(n), 0));
    endtask

    task automatic zero_job(input logic [ACC_W-1:0] thr);
        @(negedge clk);
        start = 1'b1; word_count = '0; threshold = thr;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R8", "zero-length done next cycle", W'(done), 1);
        check(ones_total == '0, "R8", "zero-length total", W'(ones_total), 0);
        check(valid == (thr == '0), "R8", "zero-length valid", W'(valid), W'(thr == '0));
        check(r_empty, "R8", "zero-length pushes nothing", W'(r_empty), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !busy && !valid && r_empty && ones_total == '0,
              "R3", "reset state", W'({done, busy, valid, r_empty}), W'(4'b0001));

        timing_job(3);                       // R6 cycle cost, R1 order
        zero_job('0);                        // R8 pass at threshold 0
        zero_job(ACC_W'(5));                 // R8 fail above 0
        run_job(4, 0, 0, 0, 1, 1'b0);        // R4 equality passes
        run_job(4, 1, 0, 0, 1, 1'b0);        // R4 one above fails
        run_job(5, -3, 0, 0, 1, 1'b1);       // R3 start while busy ignored
        run_job(6, 0, 0, 95, 2, 1'b0);       // R7 heavy result back-pressure
        run_job(6, 0, 80, 0, 0, 1'b0);       // R7 starved operands
        for (int j = 0; j < 20; j++) begin
            run_job(1 + ($urandom() % 12), int'($urandom() % 9) - 4,
                    $urandom() % 60, $urandom() % 60, $urandom() % 3, j[0]);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule